// File: doc/BRIEF.md
# UART Transmitter with Infrared Pulse Encoding

This block serialises bytes into asynchronous frames on a single transmit line. Each frame has a start bit, 8 or 9 data bits sent least significant bit first, and a stop bit. Every bit cell lasts 16 periods of an external oversampling tick. The line can be written in plain NRZ levels or as infrared-style return-to-zero pulses, and an inversion control flips every level the block drives, including the resting level.

Besides data frames, the block can emit a break: a run of space bit times followed by one bit time of mark. The run length depends on the frame size and on a long-break control. A break request is served only between frames. When a break request and a data byte are both offered to an idle transmitter, the break is sent first and the byte is held off. For half-duplex wiring on one shared pin, an output-enable is produced that either always drives or follows a direction control.

Top module: `irtx_uart`

## Requirements
- R1: A frame is start (space), then the data bits LSB first, then stop (mark). Each bit cell spans 16 `tick16` pulses, and the bit level changes only on a tick.
- R2: With `cfg_nine`=1 the frame carries 9 data bits, and `in_data[8]` is sent last. With `cfg_nine`=0 it carries `in_data[7:0]` only.
- R3: With `cfg_irda`=0 the line carries the bit level XOR `cfg_invert`. The resting line is therefore high when `cfg_invert`=0 and low when it is 1.
- R4: With `cfg_irda`=1 a space bit produces a pulse at the non-resting level during sub-bit phases 7, 8 and 9 of the cell, where phase p is the interval after p ticks into the cell. A mark bit leaves the line at rest. The resting level is `cfg_invert`: low for normal polarity and high for inverted.
- R5: A break is 10 bit times of space for 8-bit frames and 11 for 9-bit frames. With `cfg_longbrk`=1 these become 13 and 14.
- R6: Every break is followed by exactly one bit time of mark before the next frame can start.
- R7: A `brk_req` raised while a frame is in progress does not alter that frame. If the request is still held, the break begins immediately after the frame's stop bit.
- R8: When `brk_req` and `in_valid` are both high at an idle transmitter, `in_ready` is low, the break goes out first, and the held byte is taken right after the break's trailing mark.
- R9: `in_ready` is high only when the transmitter is idle with no break request. `busy` is high from the start bit through the end of the stop bit, and through a break and its mark.
- R10: `tx_oe` is 1 when `cfg_onewire`=0. When `cfg_onewire`=1 it equals `cfg_drive`.
- R11: After reset `busy`=0, `in_ready`=1, and `tx_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| in_valid | input | 1 | Byte offered |
| in_data | input | 9 | Byte to send (bit 8 used in 9-bit mode) |
| in_ready | output | 1 | Byte taken on this cycle when in_valid is high |
| brk_req | input | 1 | Level request to send a break |
| cfg_invert | input | 1 | Invert all driven line levels |
| cfg_irda | input | 1 | Pulse encoding instead of NRZ |
| cfg_nine | input | 1 | 9 data bits per frame |
| cfg_longbrk | input | 1 | Longer break length |
| cfg_onewire | input | 1 | Shared-pin half-duplex mode |
| cfg_drive | input | 1 | Pin direction in shared-pin mode (1 = drive) |
| tx_o | output | 1 | Line level |
| tx_oe | output | 1 | Line output enable |
| busy | output | 1 | Frame or break in progress |

## Verification
The functions that can meet in one cycle are break scheduling and byte acceptance. The bench offers a byte and a break request on the same idle cycle, expects `in_ready` low there, and then follows the line continuously through the break, its trailing mark and the frame that follows. A second case raises the break request in the middle of a data frame. There the frame must come out unchanged, with the break starting on the cycle after the stop bit ends. Both cases are judged tick by tick against a line image that the bench builds from the requirements.

// File: rtl/irtx_pkg.sv
package irtx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP,
    ST_BRK,
    ST_BRK_MARK
  } tx_state_e;
endpackage

// File: rtl/irtx_seq.sv
module irtx_seq
  import irtx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_MAX   = 9,
  parameter int BRK_BASE   = 10,
  parameter int BRK_EXTRA  = 3,
  localparam int PH_W  = $clog2(OVERSAMPLE),
  localparam int BIT_W = $clog2(BRK_BASE + BRK_EXTRA + 2)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                in_valid,
  input  logic [DATA_MAX-1:0] in_data,
  output logic                in_ready,
  input  logic                brk_req,
  input  logic                cfg_nine,
  input  logic                cfg_longbrk,
  output logic                raw_bit,
  output logic [PH_W-1:0]     phase,
  output logic                busy
);
  localparam int CHK_W = $clog2(OVERSAMPLE * (BRK_BASE + BRK_EXTRA + 1) + 1);

  tx_state_e           state_q, state_d;
  logic [PH_W-1:0]     phase_q, phase_d;
  logic [BIT_W-1:0]    bit_q, bit_d;
  logic [BIT_W-1:0]    brklen_q, brklen_d;
  logic [DATA_MAX-1:0] shift_q, shift_d;
  logic                nine_q, nine_d;
  logic                last_tick;
  logic [BIT_W-1:0]    last_data;
  logic [BIT_W-1:0]    brk_sel;

  assign last_tick = tick && (phase_q == PH_W'(OVERSAMPLE - 1));
  assign last_data = nine_q ? BIT_W'(DATA_MAX - 1) : BIT_W'(DATA_MAX - 2);
  assign brk_sel   = BIT_W'(BRK_BASE + (cfg_nine ? 1 : 0) + (cfg_longbrk ? BRK_EXTRA : 0));

  always_comb begin
    state_d  = state_q;
    phase_d  = phase_q;
    bit_d    = bit_q;
    brklen_d = brklen_q;
    shift_d  = shift_q;
    nine_d   = nine_q;
    if (state_q != ST_IDLE && tick) begin
      phase_d = last_tick ? '0 : phase_q + 1'b1;
    end
    case (state_q)
      ST_IDLE: begin
        if (brk_req) begin
          state_d  = ST_BRK;
          phase_d  = '0;
          bit_d    = '0;
          brklen_d = brk_sel;
        end else if (in_valid) begin
          state_d = ST_START;
          phase_d = '0;
          shift_d = in_data;
          nine_d  = cfg_nine;
        end
      end
      ST_START: begin
        if (last_tick) begin
          state_d = ST_DATA;
          bit_d   = '0;
        end
      end
      ST_DATA: begin
        if (last_tick) begin
          shift_d = shift_q >> 1;
          if (bit_q == last_data) state_d = ST_STOP;
          else bit_d = bit_q + 1'b1;
        end
      end
      ST_STOP: begin
        if (last_tick) state_d = ST_IDLE;
      end
      ST_BRK: begin
        if (last_tick) begin
          if (bit_q == brklen_q - 1'b1) state_d = ST_BRK_MARK;
          else bit_d = bit_q + 1'b1;
        end
      end
      ST_BRK_MARK: begin
        if (last_tick) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      phase_q  <= '0;
      bit_q    <= '0;
      brklen_q <= '0;
      shift_q  <= '0;
      nine_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      phase_q  <= phase_d;
      bit_q    <= bit_d;
      brklen_q <= brklen_d;
      shift_q  <= shift_d;
      nine_q   <= nine_d;
    end
  end

  always_comb begin
    case (state_q)
      ST_START, ST_BRK: raw_bit = 1'b0;
      ST_DATA:          raw_bit = shift_q[0];
      default:          raw_bit = 1'b1;
    endcase
  end

  assign phase    = phase_q;
  assign busy     = (state_q != ST_IDLE);
  assign in_ready = (state_q == ST_IDLE) && !brk_req;

  // Checker: ticks spent in the break run
  logic [CHK_W-1:0] chk_ticks;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_ticks <= '0;
    else if (state_q != ST_BRK) chk_ticks <= '0;
    else if (tick) chk_ticks <= chk_ticks + 1'b1;
  end

  p_phase_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && !tick) |=> (phase_q == $past(phase_q)));

  p_brk_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == ST_BRK_MARK) |->
      ((int'($past(chk_ticks)) + 1) == OVERSAMPLE * int'($past(brklen_q))));

  p_no_brk_mid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START || state_q == ST_DATA) |=> (state_q != ST_BRK));

  p_brk_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && brk_req) |=> (state_q == ST_BRK));

  p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> busy);
endmodule

// File: rtl/irtx_enc.sv
module irtx_enc #(
  parameter int OVERSAMPLE  = 16,
  parameter int PULSE_FIRST = 7,
  parameter int PULSE_LAST  = 9,
  localparam int PH_W = $clog2(OVERSAMPLE)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            raw_bit,
  input  logic [PH_W-1:0] phase,
  input  logic            cfg_irda,
  input  logic            cfg_invert,
  output logic            tx_o
);
  logic in_window;
  logic level_d;
  logic tx_q;

  assign in_window = (phase >= PH_W'(PULSE_FIRST)) && (phase <= PH_W'(PULSE_LAST));

  always_comb begin
    if (cfg_irda) level_d = (!raw_bit && in_window) ^ cfg_invert;
    else          level_d = raw_bit ^ cfg_invert;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_q <= 1'b1;
    else        tx_q <= level_d;
  end

  assign tx_o = tx_q;

  p_ir_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_irda && !in_window) |=> (tx_q == $past(cfg_invert)));

  p_ir_mark_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_irda && raw_bit) |=> (tx_q == $past(cfg_invert)));
endmodule

// File: rtl/irtx_pin.sv
module irtx_pin (
  input  logic cfg_onewire,
  input  logic cfg_drive,
  output logic tx_oe
);
  assign tx_oe = cfg_onewire ? cfg_drive : 1'b1;
endmodule

// File: rtl/irtx_uart.sv
module irtx_uart #(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_MAX   = 9,
  parameter int BRK_BASE   = 10,
  parameter int BRK_EXTRA  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick16,
  input  logic                in_valid,
  input  logic [DATA_MAX-1:0] in_data,
  output logic                in_ready,
  input  logic                brk_req,
  input  logic                cfg_invert,
  input  logic                cfg_irda,
  input  logic                cfg_nine,
  input  logic                cfg_longbrk,
  input  logic                cfg_onewire,
  input  logic                cfg_drive,
  output logic                tx_o,
  output logic                tx_oe,
  output logic                busy
);
  localparam int PH_W = $clog2(OVERSAMPLE);

  logic [1:0]      rst_sync;
  logic            rst_n_s;
  logic            raw_bit;
  logic [PH_W-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  irtx_seq #(
    .OVERSAMPLE(OVERSAMPLE), .DATA_MAX(DATA_MAX),
    .BRK_BASE(BRK_BASE), .BRK_EXTRA(BRK_EXTRA)
  ) u_seq (
    .clk(clk), .rst_n(rst_n_s), .tick(tick16),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .brk_req(brk_req), .cfg_nine(cfg_nine), .cfg_longbrk(cfg_longbrk),
    .raw_bit(raw_bit), .phase(phase), .busy(busy)
  );

  irtx_enc #(.OVERSAMPLE(OVERSAMPLE)) u_enc (
    .clk(clk), .rst_n(rst_n_s), .raw_bit(raw_bit), .phase(phase),
    .cfg_irda(cfg_irda), .cfg_invert(cfg_invert), .tx_o(tx_o)
  );

  irtx_pin u_pin (
    .cfg_onewire(cfg_onewire), .cfg_drive(cfg_drive), .tx_oe(tx_oe)
  );
endmodule

// File: tb/irtx_uart_tb.sv
`timescale 1ns/1ps
module irtx_uart_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       in_valid = 1'b0;
  logic [8:0] in_data = '0;
  logic       brk_req = 1'b0;
  logic       cfg_invert = 1'b0, cfg_irda = 1'b0, cfg_nine = 1'b0;
  logic       cfg_longbrk = 1'b0, cfg_onewire = 1'b0, cfg_drive = 1'b0;
  logic       in_ready, tx_o, tx_oe, busy;

  int errors = 0;
  int checks = 0;
  bit exp_raw [0:63];
  int exp_len = 0;
  event pre_tick;

  irtx_uart u_dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .brk_req(brk_req),
    .cfg_invert(cfg_invert), .cfg_irda(cfg_irda), .cfg_nine(cfg_nine),
    .cfg_longbrk(cfg_longbrk), .cfg_onewire(cfg_onewire), .cfg_drive(cfg_drive),
    .tx_o(tx_o), .tx_oe(tx_oe), .busy(busy)
  );

  initial forever #2.5 clk = ~clk;

  // tick every fourth cycle; pre_tick fires on the negedge before a tick edge
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      tick16 = (cnt == 3);
      cnt = (cnt + 1) % 4;
      if (tick16) -> pre_tick;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic add_frame(logic [8:0] d, bit nine);
    exp_raw[exp_len++] = 1'b0;
    for (int i = 0; i < (nine ? 9 : 8); i++) exp_raw[exp_len++] = d[i];
    exp_raw[exp_len++] = 1'b1;
  endtask

  task automatic add_break(int len);
    for (int i = 0; i < len; i++) exp_raw[exp_len++] = 1'b0;
    exp_raw[exp_len++] = 1'b1;
  endtask

  task automatic launch(string req, bit use_data, logic [8:0] d, bit use_brk, int exp_ready);
    @(pre_tick);
    @(negedge clk);
    in_valid = use_data;
    in_data  = d;
    brk_req  = use_brk;
    #0.1;
    chk(req, "in_ready at launch", int'(in_ready), exp_ready);
  endtask

  task automatic capture(string req, bit ir, bit inv, int brk_on, int brk_off, int val_off);
    for (int i = 0; i < exp_len * 16; i++) begin
      int ph;
      bit r, e;
      @(pre_tick);
      ph = i % 16;
      r  = exp_raw[i / 16];
      e  = ir ? (((!r) && ph >= 7 && ph <= 9) ^ inv) : (r ^ inv);
      chk(req, $sformatf("tx_o sample %0d", i), int'(tx_o), int'(e));
      chk("R9", $sformatf("busy sample %0d", i), int'(busy), 1);
      chk("R9", $sformatf("in_ready sample %0d", i), int'(in_ready), 0);
      if (i == brk_on)  brk_req  = 1'b1;
      if (i == brk_off) brk_req  = 1'b0;
      if (i == val_off) in_valid = 1'b0;
    end
    repeat (2) @(negedge clk);
    chk("R9", "busy after end", int'(busy), 0);
    chk("R9", "in_ready after end", int'(in_ready), 1);
    chk(ir ? "R4" : "R3", "rest level after end", int'(tx_o), int'(ir ? inv : !inv));
  endtask

  task automatic t_reset();
    chk("R11", "busy", int'(busy), 0);
    chk("R11", "in_ready", int'(in_ready), 1);
    chk("R11", "tx_o", int'(tx_o), 1);
    chk("R10", "tx_oe default", int'(tx_oe), 1);
  endtask

  task automatic t_frame(string req, logic [8:0] d, bit nine, bit ir, bit inv);
    @(negedge clk);
    cfg_nine = nine; cfg_irda = ir; cfg_invert = inv;
    repeat (2) @(negedge clk);
    chk(ir ? "R4" : "R3", "rest level before frame", int'(tx_o), int'(ir ? inv : !inv));
    exp_len = 0;
    add_frame(d, nine);
    launch(req, 1'b1, d, 1'b0, 1);
    capture(req, ir, inv, -1, -1, 0);
  endtask

  task automatic t_break(bit nine, bit longb, bit ir);
    int len;
    len = 10 + (nine ? 1 : 0) + (longb ? 3 : 0);
    @(negedge clk);
    cfg_nine = nine; cfg_longbrk = longb; cfg_irda = ir; cfg_invert = 1'b0;
    exp_len = 0;
    add_break(len);
    launch("R5", 1'b0, 9'h000, 1'b1, 0);
    capture($sformatf("R5 R6 len%0d", len), ir, 1'b0, -1, 0, -1);
  endtask

  // R7: break request during a frame waits for the stop bit
  task automatic t_brk_mid_frame();
    @(negedge clk);
    cfg_nine = 1'b0; cfg_longbrk = 1'b0; cfg_irda = 1'b0; cfg_invert = 1'b0;
    exp_len = 0;
    add_frame(9'h0C6, 1'b0);
    add_break(10);
    launch("R7", 1'b1, 9'h0C6, 1'b0, 1);
    capture("R7", 1'b0, 1'b0, 40, 160, 0);
  endtask

  // R8: break and byte offered together
  task automatic t_collision();
    @(negedge clk);
    cfg_nine = 1'b1; cfg_longbrk = 1'b1; cfg_irda = 1'b0; cfg_invert = 1'b1;
    exp_len = 0;
    add_break(14);
    add_frame(9'h12D, 1'b1);
    launch("R8", 1'b1, 9'h12D, 1'b1, 0);
    capture("R8", 1'b0, 1'b1, -1, 0, 15 * 16);
  endtask

  task automatic t_pin();
    cfg_onewire = 1'b0; cfg_drive = 1'b0; @(negedge clk);
    chk("R10", "oe wire mode off, dir 0", int'(tx_oe), 1);
    cfg_onewire = 1'b1; cfg_drive = 1'b0; @(negedge clk);
    chk("R10", "oe wire mode on, dir 0", int'(tx_oe), 0);
    cfg_drive = 1'b1; @(negedge clk);
    chk("R10", "oe wire mode on, dir 1", int'(tx_oe), 1);
    cfg_onewire = 1'b0; cfg_drive = 1'b0; @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_frame("R1", 9'h0A5, 1'b0, 1'b0, 1'b0);
    t_frame("R3", 9'h03C, 1'b0, 1'b0, 1'b1);
    t_frame("R2", 9'h1C3, 1'b1, 1'b0, 1'b0);
    t_frame("R2", 9'h0FF, 1'b0, 1'b0, 1'b0);
    t_frame("R4", 9'h055, 1'b0, 1'b1, 1'b0);
    t_frame("R4", 9'h0F2, 1'b1, 1'b1, 1'b1);
    t_break(1'b0, 1'b0, 1'b0);
    t_break(1'b1, 1'b0, 1'b0);
    t_break(1'b0, 1'b1, 1'b0);
    t_break(1'b1, 1'b1, 1'b1);
    t_brk_mid_frame();
    t_collision();
    t_pin();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule